// File: doc/BRIEF.md
# Power Resource Dependency Sequencer

This block decides, on every clock, which power resources (regulators, oscillators, PLLs and similar) must be switched on. Software programs a dependency mask and an up time and a down time for each resource through a simple write-strobe port. A request bitmask names the resources that clients want. The block expands that set through the dependency masks into the full set of resources that are needed. It then raises or lowers one enable line per resource, and follows each change with a countdown during which the resource is reported as pending.

A resource is switched on only once every resource it depends on is available. A resource is switched off only once nothing still on, or still ramping down, depends on it. Resources listed in the always-on parameter are on from reset and are never switched off. For each resource the block reports three status bits: its enable line, its pending flag and its availability (enabled and not pending).

Top module: `pwr_dep_seq`

## Requirements
- R1: While and after reset, with no requests, `res_en` equals the always-on mask, `res_pend` is all zero, and every timer is zero.
- R2: On a clock edge with `wr_en` high, `wr_fld` selects what is written for resource `wr_idx`. Code 0 is the dependency mask (bit j set means the resource needs resource j). Code 1 is the up time. Code 2 is the down time. Code 3 writes nothing. With `wr_en` low, nothing is written.
- R3: The needed set is the closure of `req` and the always-on mask through the dependency masks. A request for one resource brings up its whole dependency chain, and no resource is enabled unless it is in that set.
- R4: A resource's enable rises only in the cycle after every resource in its dependency mask was available.
- R5: When a resource's enable changes, its timer is loaded with the matching up time or down time and its pending flag is set. The timer counts down once per cycle. The flag clears on the edge on which the timer reaches zero, so it stays high for max(T,1) cycles.
- R6: `res_avail` for each resource is high exactly when its enable is high and its pending flag is low.
- R7: A resource that is no longer needed is switched off (enable drops, pending for its down time). This happens only when no other resource whose enable or pending flag is high has it in its dependency mask.
- R8: An always-on resource stays enabled whatever the requests are.
- R9: A resource's own bit in its dependency mask is ignored. No new transition starts while a resource is pending, so a resource that is requested again while it is ramping down turns back on only after its down time has run out.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | NRES | Request bitmask, one bit per resource |
| wr_en | input | 1 | Write strobe for the configuration port |
| wr_fld | input | 2 | Field selector: 0 dependency mask, 1 up time, 2 down time |
| wr_idx | input | IW | Resource selected by the write |
| wr_data | input | DW | Write data |
| res_en | output | NRES | Enable line per resource |
| res_pend | output | NRES | Transition in progress per resource |
| res_avail | output | NRES | Enabled and settled per resource |

## Verification
The hardest case to reach is a resource that is requested again while it is still ramping down. Its supplier must stay held because the ramping-down resource still counts as a dependent, and the re-enable must wait for the down timer. To get there, the stimulus brings up a two-level chain, drops the request, and raises it again one cycle later, while the down time is long enough to cover several cycles. A three-level chain with different up times and a zero up time also sets the staggered order in which resources come up and go down. The scoreboard checks that order cycle by cycle.

// File: rtl/pds_pkg.sv
`timescale 1ns/1ps
package pds_pkg;

   // Field selector codes of the configuration write port
   typedef enum logic [1:0] {
      FLD_DEP  = 2'd0,
      FLD_UP   = 2'd1,
      FLD_DOWN = 2'd2,
      FLD_NONE = 2'd3
   } fld_e;

endpackage

// File: rtl/pds_regs.sv
`timescale 1ns/1ps
module pds_regs #(
   parameter int NRES = 16,
   parameter int TW   = 16,
   parameter int DW   = 16,
   parameter int IW   = 4
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic                           wr_en,
   input  logic [1:0]                     wr_fld,
   input  logic [IW-1:0]                  wr_idx,
   input  logic [DW-1:0]                  wr_data,
   output logic [NRES-1:0][NRES-1:0]      dep_o,
   output logic [NRES-1:0][TW-1:0]        up_o,
   output logic [NRES-1:0][TW-1:0]        dn_o
);
   import pds_pkg::*;

   logic [NRES-1:0][NRES-1:0] dep_q;
   logic [NRES-1:0][TW-1:0]   up_q;
   logic [NRES-1:0][TW-1:0]   dn_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dep_q <= '0;
         up_q  <= '0;
         dn_q  <= '0;
      end else if (wr_en) begin
         for (int i = 0; i < NRES; i++) begin
            if (wr_idx == IW'(i)) begin
               case (fld_e'(wr_fld))
                  FLD_DEP:  dep_q[i] <= wr_data[NRES-1:0] & ~(NRES'(1) << i);
                  FLD_UP:   up_q[i]  <= wr_data[TW-1:0];
                  FLD_DOWN: dn_q[i]  <= wr_data[TW-1:0];
                  default:  ;
               endcase
            end
         end
      end
   end

   assign dep_o = dep_q;
   assign up_o  = up_q;
   assign dn_o  = dn_q;

endmodule

// File: rtl/pds_closure.sv
`timescale 1ns/1ps
module pds_closure #(
   parameter int              NRES = 16,
   parameter logic [NRES-1:0] AON  = '0
) (
   input  logic [NRES-1:0]            req_i,
   input  logic [NRES-1:0][NRES-1:0]  dep_i,
   output logic [NRES-1:0]            need_o
);
   // A chain of NRES resources needs at most NRES-1 expansion steps
   localparam int LEVELS = (NRES > 1) ? NRES - 1 : 1;

   always_comb begin
      logic [NRES-1:0] cur;
      logic [NRES-1:0] nxt;
      cur = req_i | AON;
      for (int l = 0; l < LEVELS; l++) begin
         nxt = cur;
         for (int i = 0; i < NRES; i++) begin
            if (cur[i]) nxt = nxt | dep_i[i];
         end
         cur = nxt;
      end
      need_o = cur;
   end

endmodule

// File: rtl/pds_slot.sv
`timescale 1ns/1ps
module pds_slot #(
   parameter int TW     = 16,
   parameter bit IS_AON = 1'b0
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          need_i,
   input  logic          deps_ok_i,
   input  logic          held_i,
   input  logic [TW-1:0] up_t_i,
   input  logic [TW-1:0] dn_t_i,
   output logic          en_o,
   output logic          pend_o,
   output logic [TW-1:0] tmr_o
);
   logic          en_q;
   logic          pend_q;
   logic [TW-1:0] tmr_q;
   logic          go_up;
   logic          go_down;

   assign go_up = need_i && !en_q && deps_ok_i;

   generate
      if (IS_AON) begin : g_aon
         assign go_down = 1'b0;
      end else begin : g_norm
         assign go_down = !need_i && en_q && !held_i;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q   <= IS_AON;
         pend_q <= 1'b0;
         tmr_q  <= '0;
      end else if (pend_q) begin
         if (tmr_q <= TW'(1)) begin
            tmr_q  <= '0;
            pend_q <= 1'b0;
         end else begin
            tmr_q <= tmr_q - TW'(1);
         end
      end else if (go_up) begin
         en_q   <= 1'b1;
         pend_q <= 1'b1;
         tmr_q  <= up_t_i;
      end else if (go_down) begin
         en_q   <= 1'b0;
         pend_q <= 1'b1;
         tmr_q  <= dn_t_i;
      end
   end

   assign en_o   = en_q;
   assign pend_o = pend_q;
   assign tmr_o  = tmr_q;

endmodule

// File: rtl/pwr_dep_seq.sv
`timescale 1ns/1ps
module pwr_dep_seq #(
   parameter int              NRES = 16,
   parameter int              TW   = 16,
   parameter int              DW   = (NRES > TW) ? NRES : TW,
   parameter int              IW   = (NRES > 1) ? $clog2(NRES) : 1,
   parameter logic [NRES-1:0] AON  = NRES'(1)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [NRES-1:0] req,
   input  logic            wr_en,
   input  logic [1:0]      wr_fld,
   input  logic [IW-1:0]   wr_idx,
   input  logic [DW-1:0]   wr_data,
   output logic [NRES-1:0] res_en,
   output logic [NRES-1:0] res_pend,
   output logic [NRES-1:0] res_avail
);

   generate
      if (NRES < 2)        begin : g_bad_nres $error("NRES must be at least 2"); end
      if (TW < 1)          begin : g_bad_tw   $error("TW must be at least 1"); end
      if (DW < NRES)       begin : g_bad_dw1  $error("DW must cover a dependency mask"); end
      if (DW < TW)         begin : g_bad_dw2  $error("DW must cover a timer value"); end
      if ((1 << IW) < NRES) begin : g_bad_iw  $error("IW too narrow for NRES"); end
   endgenerate

   logic [NRES-1:0][NRES-1:0] dep_w;
   logic [NRES-1:0][TW-1:0]   up_w;
   logic [NRES-1:0][TW-1:0]   dn_w;
   logic [NRES-1:0][TW-1:0]   tmr_w;
   logic [NRES-1:0]           need_w;
   logic [NRES-1:0]           deps_ok_w;
   logic [NRES-1:0]           held_w;

   pds_regs #(.NRES(NRES), .TW(TW), .DW(DW), .IW(IW)) u_regs (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .wr_fld  (wr_fld),
      .wr_idx  (wr_idx),
      .wr_data (wr_data),
      .dep_o   (dep_w),
      .up_o    (up_w),
      .dn_o    (dn_w)
   );

   pds_closure #(.NRES(NRES), .AON(AON)) u_closure (
      .req_i  (req),
      .dep_i  (dep_w),
      .need_o (need_w)
   );

   // Readiness of suppliers and holding by dependents
   always_comb begin
      for (int i = 0; i < NRES; i++) begin
         deps_ok_w[i] = ((dep_w[i] & ~res_avail) == '0);
         held_w[i]    = 1'b0;
         for (int j = 0; j < NRES; j++) begin
            if (j != i && dep_w[j][i] && (res_en[j] || res_pend[j]))
               held_w[i] = 1'b1;
         end
      end
   end

   generate
      for (genvar g = 0; g < NRES; g++) begin : g_slot
         pds_slot #(.TW(TW), .IS_AON(AON[g])) u_slot (
            .clk       (clk),
            .rst_n     (rst_n),
            .need_i    (need_w[g]),
            .deps_ok_i (deps_ok_w[g]),
            .held_i    (held_w[g]),
            .up_t_i    (up_w[g]),
            .dn_t_i    (dn_w[g]),
            .en_o      (res_en[g]),
            .pend_o    (res_pend[g]),
            .tmr_o     (tmr_w[g])
         );
      end
   endgenerate

   assign res_avail = res_en & ~res_pend;

endmodule

// File: rtl/pwr_dep_seq_chk.sv
`timescale 1ns/1ps
module pwr_dep_seq_chk #(
   parameter int              NRES = 16,
   parameter int              TW   = 16,
   parameter logic [NRES-1:0] AON  = NRES'(1)
) (
   input logic                          clk,
   input logic                          rst_n,
   input logic [NRES-1:0]               en,
   input logic [NRES-1:0]               pend,
   input logic [NRES-1:0]               avail,
   input logic [NRES-1:0]               need,
   input logic [NRES-1:0][NRES-1:0]     dep,
   input logic [NRES-1:0][TW-1:0]       tmr
);
   logic [NRES-1:0] hold_c;

   always_comb begin
      for (int i = 0; i < NRES; i++) begin
         hold_c[i] = 1'b0;
         for (int j = 0; j < NRES; j++) begin
            if (j != i && dep[j][i] && (en[j] || pend[j])) hold_c[i] = 1'b1;
         end
      end
   end

   generate
      for (genvar g = 0; g < NRES; g++) begin : g_res
         // R4: enable rises only after every supplier was available
         a_r4_up_after_deps: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(en[g]) |-> ($past(dep[g] & ~(NRES'(1) << g) & ~avail) == '0));

         // R3: enable rises only for a needed resource
         a_r3_rise_needed: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(en[g]) |-> $past(need[g]));

         // R7: never switched off while a dependent holds it
         a_r7_no_drop_held: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(en[g]) |-> !$past(hold_c[g]));

         // R5: timer counts down one step while pending
         a_r5_tick: assert property (@(posedge clk) disable iff (!rst_n)
            (pend[g] && tmr[g] > TW'(1)) |=> (pend[g] && tmr[g] == TW'($past(tmr[g]) - TW'(1))));

         // R5: timer is idle at zero whenever nothing is pending
         a_r5_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
            !pend[g] |-> (tmr[g] == '0));

         if (AON[g]) begin : g_aon
            // R8: always-on resource stays enabled
            a_r8_aon_on: assert property (@(posedge clk) disable iff (!rst_n)
               en[g]);
         end
      end
   endgenerate

endmodule

bind pwr_dep_seq pwr_dep_seq_chk #(.NRES(NRES), .TW(TW), .AON(AON)) u_chk (
   .clk   (clk),
   .rst_n (rst_n),
   .en    (res_en),
   .pend  (res_pend),
   .avail (res_avail),
   .need  (need_w),
   .dep   (dep_w),
   .tmr   (tmr_w)
);

// File: tb/pwr_dep_seq_test.sv
`timescale 1ns/1ps
module pwr_dep_seq_test;

   typedef struct {
      int          cyc;
      logic [15:0] en;
      logic [15:0] pend;
      string       tag;
   } exp_t;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] req = '0;
   logic        wr_en = 1'b0;
   logic [1:0]  wr_fld = '0;
   logic [3:0]  wr_idx = '0;
   logic [15:0] wr_data = '0;
   logic [15:0] res_en;
   logic [15:0] res_pend;
   logic [15:0] res_avail;

   int   cyc = 0;
   int   checks = 0;
   int   errors = 0;
   bit   done = 1'b0;
   exp_t q[$];

   always #10 clk = ~clk;

   pwr_dep_seq uut (
      .clk       (clk),
      .rst_n     (rst_n),
      .req       (req),
      .wr_en     (wr_en),
      .wr_fld    (wr_fld),
      .wr_idx    (wr_idx),
      .wr_data   (wr_data),
      .res_en    (res_en),
      .res_pend  (res_pend),
      .res_avail (res_avail)
   );

   always @(posedge clk) begin
      if (!rst_n) cyc <= 0;
      else        cyc <= cyc + 1;
   end

   // Monitor: pops expected items at their cycle and compares
   always @(negedge clk) begin
      exp_t it;
      if (rst_n) begin
         while (q.size() > 0 && q[0].cyc <= cyc) begin
            it = q.pop_front();
            checks++;
            if (it.cyc != cyc || res_en !== it.en || res_pend !== it.pend ||
                res_avail !== (it.en & ~it.pend)) begin
               errors++;
               $display("FAIL %s @cyc %0d: en=%h pend=%h avail=%h expected en=%h pend=%h avail=%h",
                        it.tag, cyc, res_en, res_pend, res_avail,
                        it.en, it.pend, it.en & ~it.pend);
            end
         end
      end
   end

   task automatic step(int n);
      repeat (n) begin
         @(posedge clk);
         #2;
      end
   endtask

   task automatic expect_at(int c, logic [15:0] e, logic [15:0] p, string tag);
      exp_t it;
      it.cyc = c; it.en = e; it.pend = p; it.tag = tag;
      q.push_back(it);
   endtask

   task automatic wr(logic [1:0] f, logic [3:0] idx, logic [15:0] d);
      wr_en = 1'b1; wr_fld = f; wr_idx = idx; wr_data = d;
      step(1);
      wr_en = 1'b0;
   endtask

   initial begin
      int k;
      step(3);
      rst_n = 1'b1;
      expect_at(cyc, 16'h0001, 16'h0000, "R1 reset state");
      step(2);

      // Resource 3 -> 2 -> 1 -> 0(always-on); bit 3 in its own mask is ignored (R9)
      wr(2'd0, 4'd3, 16'h000C);
      wr(2'd0, 4'd2, 16'h0002);
      wr(2'd0, 4'd1, 16'h0001);
      wr(2'd1, 4'd1, 16'd2);
      wr(2'd1, 4'd2, 16'd3);
      wr(2'd1, 4'd3, 16'd0);
      wr(2'd2, 4'd1, 16'd1);
      wr(2'd2, 4'd2, 16'd2);
      wr(2'd2, 4'd3, 16'd1);
      wr(2'd3, 4'd2, 16'd9);         // R2: code 3 writes nothing
      wr_fld = 2'd1; wr_idx = 4'd2; wr_data = 16'd9;
      step(1);                       // R2: strobe low, no write
      expect_at(cyc, 16'h0001, 16'h0000, "R8 R1 idle after config");
      step(1);

      // Bring-up of the chain
      req = 16'h0008;
      k = cyc;
      expect_at(k+1, 16'h0003, 16'h0002, "R3 R5 supplier 1 up first");
      expect_at(k+2, 16'h0003, 16'h0002, "R5 supplier 1 still pending");
      expect_at(k+3, 16'h0003, 16'h0000, "R5 R6 supplier 1 available");
      expect_at(k+4, 16'h0007, 16'h0004, "R4 resource 2 after 1 ready");
      expect_at(k+6, 16'h0007, 16'h0004, "R2 R5 up time 3 kept");
      expect_at(k+7, 16'h0007, 16'h0000, "R6 resource 2 available");
      expect_at(k+8, 16'h000F, 16'h0008, "R4 R9 resource 3 up, zero time");
      expect_at(k+9, 16'h000F, 16'h0000, "R5 R6 zero time pends one cycle");
      step(12);

      // Power-down ordering
      req = 16'h0000;
      k = cyc;
      expect_at(k+1, 16'h0007, 16'h0008, "R7 top goes down first");
      expect_at(k+2, 16'h0007, 16'h0000, "R7 resource 2 held by ramping dependent");
      expect_at(k+3, 16'h0003, 16'h0004, "R7 resource 2 down");
      expect_at(k+4, 16'h0003, 16'h0004, "R5 down time 2 pending");
      expect_at(k+5, 16'h0003, 16'h0000, "R7 resource 1 held");
      expect_at(k+6, 16'h0001, 16'h0002, "R7 R8 resource 1 down, 0 stays");
      expect_at(k+7, 16'h0001, 16'h0000, "R8 only always-on left");
      step(10);

      // Middle of chain only
      req = 16'h0004;
      k = cyc;
      expect_at(k+3, 16'h0003, 16'h0000, "R3 only needed supplier up");
      expect_at(k+7, 16'h0007, 16'h0000, "R3 resource 2 settled, 3 untouched");
      step(10);

      // Re-request during ramp-down
      req = 16'h0000;
      k = cyc;
      expect_at(k+1, 16'h0003, 16'h0004, "R7 resource 2 ramping down");
      expect_at(k+2, 16'h0003, 16'h0004, "R9 no restart while pending");
      expect_at(k+3, 16'h0003, 16'h0000, "R9 R7 supplier kept, 2 off");
      expect_at(k+4, 16'h0007, 16'h0004, "R9 restart after down time");
      expect_at(k+7, 16'h0007, 16'h0000, "R6 back to available");
      step(1);
      req = 16'h0004;
      step(12);

      if (q.size() != 0) begin
         errors++;
         $display("FAIL scoreboard: %0d expected items left, expected 0", q.size());
      end
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: run hung, actual cyc=%0d expected finish", cyc);
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

endmodule